// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block produces the strobes and port values an 8-bit microcontroller core needs to reach external program and data memory. The oscillator clock drives a machine cycle of twelve periods, split into six states of two phases. In every machine cycle the block runs one operation taken from the core: an instruction fetch, a code-space read, a data access with a 16-bit address, a data access with an 8-bit address, or nothing. It drives the address-latch strobe, the active-low program-store strobe, and the active-low read and write strobes. The low address byte and the data byte share one 8-bit port. The high address byte, or the port's own latch value, goes out on a second port.

The address-latch strobe runs without a break at one sixth of the oscillator rate, so a board can use it as a clock. A data access replaces the second address-latch pulse and both program-store pulses of its cycle with a read or write strobe. A suppression input stops the address-latch strobe except in code-read and data cycles. A reset pin is honoured only after it has stayed high for two full machine cycles.

Top module: `bus_seq_top`

## Requirements
- R1: `coreReset` rises only on the 24th consecutive clock edge that samples `rstPin` high. It falls on the first edge that samples the pin low. While it is high, `ale`=0, `psenN`=`rdN`=`wrN`=1 and `loPortOe`=0.
- R2: With no suppression, `ale` is high in steps 0, 1, 6 and 7 of every non-data machine cycle (steps 0..11, step 0 being the cycle right after `reqReady`). That is two pulses per twelve clocks.
- R3: For a fetch (`reqKind`=00) or code read (01) with `internalRomEn`=0, `psenN` is low in steps 2-4 and 8-10. `loPortOut` drives address bits [7:0] in steps 0-1 and bits [7:0] of address+1 in steps 6-7, and is released otherwise. `hiPortOut` carries the matching upper byte (address in steps 0-5, address+1 in steps 6-11).
- R4: A fetch or code read from external memory returns `loPortIn`, as sampled at the end of steps 4 and 10, on `rdData` with `rdValid` high in steps 5 and 11.
- R5: In a data cycle (`reqKind` 10 or 11), `ale` is high only in steps 0-1, and `psenN` stays high for the whole cycle.
- R6: A data read (`reqWrite`=0) drives `rdN` low in steps 4-9 and releases the low port from step 2. It returns the `loPortIn` value sampled at the end of step 9 with `rdValid` high in step 10.
- R7: A data write drives `wrN` low in steps 4-9 and holds `reqWdata` on `loPortOut` in steps 2-10. The port is released in step 11, before the next address-latch pulse.
- R8: `hiPortOut` shows address bits [15:8] during a 16-bit data access (10) and `hiLatch` during an 8-bit access (11).
- R9: A fetch or code read with `internalRomEn`=1 makes no program-store pulse, leaves the low port released, and shows `hiLatch` on the high port.
- R10: With `aleOff`=1, `ale` stays low in fetch and idle cycles. It keeps its normal pulses in code-read and data cycles.
- R11: A machine cycle with no request makes no read, write or program-store strobe, leaves the low port released and shows `hiLatch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arstN | input | 1 | Power-on reset, active low, asynchronous |
| rstPin | input | 1 | Reset pin, filtered over two machine cycles |
| coreReset | output | 1 | Filtered reset to the core |
| reqValid | input | 1 | Request present for the next machine cycle |
| reqKind | input | 2 | 00 fetch, 01 code read, 10 data 16-bit address, 11 data 8-bit address |
| reqWrite | input | 1 | Data access is a write |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Write data |
| reqReady | output | 1 | Last step of a machine cycle; request sampled at this edge |
| aleOff | input | 1 | Suppress address-latch strobe outside code-read and data cycles |
| internalRomEn | input | 1 | Fetches use on-chip program memory |
| hiLatch | input | 8 | High port latch contents |
| loPortIn | input | 8 | Low port input pins |
| ale | output | 1 | Address-latch strobe |
| psenN | output | 1 | Program-store strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| loPortOut | output | 8 | Low port address/data out |
| loPortOe | output | 1 | Low port output enable |
| hiPortOut | output | 8 | High port out |
| rdData | output | 8 | Captured read byte |
| rdValid | output | 1 | `rdData` valid for one clock |

## Verification
The strobes and port values are decoded directly from the step counter, so each one is due in the same clock as its step. The bench aligns to `reqReady`, then compares every output on the falling edge of each of the twelve steps against a table built from the requirements. Read data goes through one capture register, so `rdValid` and `rdData` are checked one step after the sampling step (steps 5, 11 and 10). The reset filter is checked on the exact edge count: still low after 23 high edges, high after 24.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH  = 2'b00,
    KIND_CODERD = 2'b01,
    KIND_DATA16 = 2'b10,
    KIND_DATA8  = 2'b11
  } req_kind_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadOp;
    logic driveAddr;
    logic driveData;
    logic useAddrHi;
    logic useNext;
    logic capture;
  } dp_strobe_t;
endpackage

// File: rtl/bus_seq_rstflt.sv
module bus_seq_rstflt #(
  parameter int LIMIT = 24
) (
  input  logic clk,
  input  logic arstN,
  input  logic rstPin,
  output logic coreReset
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] highCount;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      highCount <= '0;
      coreReset <= 1'b1;
    end else if (!rstPin) begin
      highCount <= '0;
      coreReset <= 1'b0;
    end else if (highCount == LAST) begin
      coreReset <= 1'b1;
    end else begin
      highCount <= highCount + 1'b1;
    end
  end
endmodule

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import bus_seq_pkg::*;
#(
  parameter int STATES = 6
) (
  input  logic       clk,
  input  logic       arstN,
  input  logic       coreReset,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       reqWrite,
  input  logic       aleOff,
  input  logic       internalRomEn,
  output logic       reqReady,
  output logic       ale,
  output logic       psenN,
  output logic       rdN,
  output logic       wrN,
  output dp_strobe_t strobe
);
  localparam int CYCLE_LEN = 2 * STATES;
  localparam int CW = $clog2(CYCLE_LEN);
  localparam logic [CW-1:0] LAST    = CW'(CYCLE_LEN - 1);
  localparam logic [CW-1:0] ALE2A   = CW'(STATES);
  localparam logic [CW-1:0] ALE2B   = CW'(STATES + 1);
  localparam logic [CW-1:0] PS1S    = CW'(2);
  localparam logic [CW-1:0] PS1E    = CW'(4);
  localparam logic [CW-1:0] PS2S    = CW'(STATES + 2);
  localparam logic [CW-1:0] PS2E    = CW'(STATES + 4);
  localparam logic [CW-1:0] STRB_S  = CW'(4);
  localparam logic [CW-1:0] STRB_E  = CW'(CYCLE_LEN - 3);
  localparam logic [CW-1:0] WDATA_E = CW'(CYCLE_LEN - 2);
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [CW-1:0] step;
  logic          opValid;
  req_kind_e     opKind;
  logic          opWrite;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      step    <= '0;
      opValid <= 1'b0;
      opKind  <= KIND_FETCH;
      opWrite <= 1'b0;
    end else if (coreReset) begin
      step    <= '0;
      opValid <= 1'b0;
    end else begin
      if (step == LAST) begin
        step    <= '0;
        opValid <= reqValid;
        opKind  <= req_kind_e'(reqKind);
        opWrite <= reqWrite;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  logic isCode, extCode, isData, isRead, isWrite;
  logic inAle1, inAle2, inPs1, inPs2, inStrb;

  always_comb begin
    isCode  = opValid && (opKind == KIND_FETCH || opKind == KIND_CODERD);
    extCode = isCode && !internalRomEn;
    isData  = opValid && (opKind == KIND_DATA16 || opKind == KIND_DATA8);
    isRead  = isData && !opWrite;
    isWrite = isData && opWrite;
    inAle1  = step <= ONE;
    inAle2  = step == ALE2A || step == ALE2B;
    inPs1   = step >= PS1S && step <= PS1E;
    inPs2   = step >= PS2S && step <= PS2E;
    inStrb  = step >= STRB_S && step <= STRB_E;
  end

  logic aleAllowed;
  always_comb begin
    aleAllowed = !aleOff || (opValid && opKind != KIND_FETCH);
    reqReady   = !coreReset && step == LAST;
    ale        = !coreReset && aleAllowed && (inAle1 || (inAle2 && !isData));
    psenN      = coreReset || !(extCode && (inPs1 || inPs2));
    rdN        = coreReset || !(isRead && inStrb);
    wrN        = coreReset || !(isWrite && inStrb);

    strobe.loadOp    = reqReady && reqValid;
    strobe.driveAddr = !coreReset &&
                       ((extCode && (inAle1 || inAle2)) || (isData && inAle1));
    strobe.driveData = !coreReset && isWrite && step >= PS1S && step <= WDATA_E;
    strobe.useAddrHi = !coreReset &&
                       (extCode || (isData && opKind == KIND_DATA16));
    strobe.useNext   = extCode && step >= ALE2A;
    strobe.capture   = !coreReset &&
                       ((extCode && (step == PS1E || step == PS2E)) ||
                        (isRead && step == STRB_E));
  end
endmodule

// File: rtl/bus_seq_dp.sv
module bus_seq_dp
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              arstN,
  input  dp_strobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] hiLatch,
  input  logic [DATA_W-1:0] loPortIn,
  output logic [DATA_W-1:0] loPortOut,
  output logic              loPortOe,
  output logic [DATA_W-1:0] hiPortOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [ADDR_W-1:0] curAddr;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strobe.loadOp) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobe.capture) rdData <= loPortIn;
      rdValid <= strobe.capture;
    end
  end

  always_comb begin
    curAddr   = strobe.useNext ? addrQ + 1'b1 : addrQ;
    loPortOe  = strobe.driveAddr || strobe.driveData;
    if (strobe.driveAddr)      loPortOut = curAddr[DATA_W-1:0];
    else if (strobe.driveData) loPortOut = wdataQ;
    else                       loPortOut = '0;
    hiPortOut = strobe.useAddrHi ? DATA_W'(curAddr[ADDR_W-1 -: HI_W]) : hiLatch;
  end
endmodule

// File: rtl/bus_seq_top.sv
module bus_seq_top
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int STATES   = 6,
  parameter int RST_MCYC = 2
) (
  input  logic              clk,
  input  logic              arstN,
  input  logic              rstPin,
  output logic              coreReset,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  input  logic              aleOff,
  input  logic              internalRomEn,
  input  logic [DATA_W-1:0] hiLatch,
  input  logic [DATA_W-1:0] loPortIn,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic [DATA_W-1:0] loPortOut,
  output logic              loPortOe,
  output logic [DATA_W-1:0] hiPortOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int RST_LIMIT = RST_MCYC * 2 * STATES;

  dp_strobe_t strobe;

  bus_seq_rstflt #(.LIMIT(RST_LIMIT)) u_rstflt (
    .clk(clk), .arstN(arstN), .rstPin(rstPin), .coreReset(coreReset)
  );

  bus_seq_ctrl #(.STATES(STATES)) u_ctrl (
    .clk(clk), .arstN(arstN), .coreReset(coreReset),
    .reqValid(reqValid), .reqKind(reqKind), .reqWrite(reqWrite),
    .aleOff(aleOff), .internalRomEn(internalRomEn),
    .reqReady(reqReady), .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .strobe(strobe)
  );

  bus_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .arstN(arstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .hiLatch(hiLatch),
    .loPortIn(loPortIn), .loPortOut(loPortOut), .loPortOe(loPortOe),
    .hiPortOut(hiPortOut), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/bus_seq_checker.sv
module bus_seq_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              arstN,
  input logic              rstPin,
  input logic              coreReset,
  input logic              ale,
  input logic              psenN,
  input logic              rdN,
  input logic              wrN,
  input logic              loPortOe,
  input logic [DATA_W-1:0] loPortOut,
  input logic              rdValid
);
  // R1: filtered reset rises only while the pin is high
  assert_reset_from_pin_R1: assert property (@(posedge clk) disable iff (!arstN)
    $rose(coreReset) |-> $past(rstPin));

  // R1: bus quiet during reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!arstN)
    coreReset |-> (!ale && psenN && rdN && wrN && !loPortOe));

  // R2: address-latch pulse lasts two clocks
  assert_ale_width_R2: assert property (@(posedge clk) disable iff (!arstN || coreReset)
    $rose(ale) |=> ale);

  // R3: low port released when a program-store pulse begins
  assert_psen_port_free_R3: assert property (@(posedge clk) disable iff (!arstN || coreReset)
    $fell(psenN) |-> !loPortOe);

  // R4: read-data valid is a single-clock pulse
  assert_rdvalid_pulse_R4: assert property (@(posedge clk) disable iff (!arstN || coreReset)
    rdValid |=> !rdValid);

  // R5: no program-store or address-latch pulse during a data strobe
  assert_data_exclusive_R5: assert property (@(posedge clk) disable iff (!arstN || coreReset)
    (!rdN || !wrN) |-> (psenN && !ale));

  // R6: port released while reading
  assert_read_port_free_R6: assert property (@(posedge clk) disable iff (!arstN || coreReset)
    !rdN |-> !loPortOe);

  // R7: write strobe only with data driven, and the data held steady
  assert_write_driven_R7: assert property (@(posedge clk) disable iff (!arstN || coreReset)
    !wrN |-> loPortOe);
  assert_write_stable_R7: assert property (@(posedge clk) disable iff (!arstN || coreReset)
    (!wrN && $past(!wrN)) |-> $stable(loPortOut));
endmodule

bind bus_seq_top bus_seq_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .arstN(arstN), .rstPin(rstPin), .coreReset(coreReset),
  .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
  .loPortOe(loPortOe), .loPortOut(loPortOut), .rdValid(rdValid)
);

// File: tb/bus_seq_top_bench.sv
module bus_seq_top_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic arstN, rstPin, coreReset;
  logic reqValid, reqWrite, reqReady;
  logic [1:0] reqKind;
  logic [15:0] reqAddr;
  logic [7:0] reqWdata, hiLatch, loPortIn, loPortOut, hiPortOut, rdData;
  logic aleOff, internalRomEn, ale, psenN, rdN, wrN, loPortOe, rdValid;
  logic [15:0] respAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  assign loPortIn = memByte(respAddr);

  bus_seq_top u_bus_seq_top (
    .clk(clk), .arstN(arstN), .rstPin(rstPin), .coreReset(coreReset),
    .reqValid(reqValid), .reqKind(reqKind), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .aleOff(aleOff), .internalRomEn(internalRomEn), .hiLatch(hiLatch),
    .loPortIn(loPortIn), .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .loPortOut(loPortOut), .loPortOe(loPortOe), .hiPortOut(hiPortOut),
    .rdData(rdData), .rdValid(rdValid)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // one machine cycle: request issued at reqReady, then twelve steps checked
  task automatic runCycle(input logic v, input logic [1:0] kind, input logic wr,
                          input logic [15:0] a, input logic [7:0] wd,
                          input logic off, input logic romi, input logic [7:0] hl);
    logic ext, dat, code;
    logic [15:0] a1;
    string tAle, tStr, tHi;
    while (!reqReady) @(negedge clk);
    reqValid = v; reqKind = kind; reqWrite = wr; reqAddr = a; reqWdata = wd;
    aleOff = off; internalRomEn = romi; hiLatch = hl;
    @(negedge clk);
    reqValid = 1'b0;
    code = v && (kind == 2'b00 || kind == 2'b01);
    ext  = code && !romi;
    dat  = v && kind[1];
    a1   = a + 16'd1;
    tAle = off ? "R10" : (dat ? "R5" : "R2");
    tStr = ext ? "R3" : (dat ? (wr ? "R7" : "R6") : (code ? "R9" : "R11"));
    tHi  = ext ? "R3" : (dat ? "R8" : (code ? "R9" : "R11"));
    for (int s = 0; s < 12; s++) begin
      logic eAle, ePsen, eRd, eWr, eOe, eVal;
      logic [7:0] eLo, eHi, eData;
      // responder presents the addressed byte
      if (ext) respAddr = (s < 6) ? a : a1;
      else if (dat && kind == 2'b11) respAddr = {hl, a[7:0]};
      else respAddr = a;
      eAle  = ((s <= 1) || ((s == 6 || s == 7) && !dat)) &&
              (!off || (v && kind != 2'b00));
      ePsen = !(ext && ((s >= 2 && s <= 4) || (s >= 8 && s <= 10)));
      eRd   = !(dat && !wr && s >= 4 && s <= 9);
      eWr   = !(dat && wr && s >= 4 && s <= 9);
      eOe   = 1'b0; eLo = 8'h00;
      if (ext && (s <= 1 || s == 6 || s == 7)) begin
        eOe = 1'b1; eLo = (s < 6) ? a[7:0] : a1[7:0];
      end else if (dat && s <= 1) begin
        eOe = 1'b1; eLo = a[7:0];
      end else if (dat && wr && s >= 2 && s <= 10) begin
        eOe = 1'b1; eLo = wd;
      end
      if (ext) eHi = (s < 6) ? a[15:8] : a1[15:8];
      else if (dat && kind == 2'b10) eHi = a[15:8];
      else eHi = hl;
      eVal = (ext && (s == 5 || s == 11)) || (dat && !wr && s == 10);
      if (ext) eData = memByte((s < 6) ? a : a1);
      else eData = memByte((kind == 2'b11) ? {hl, a[7:0]} : a);
      chk(tAle, "ale", {15'd0, ale}, {15'd0, eAle});
      chk(ext ? "R3" : (dat ? "R5" : tStr), "psenN", {15'd0, psenN}, {15'd0, ePsen});
      chk(tStr, "rdN", {15'd0, rdN}, {15'd0, eRd});
      chk(tStr, "wrN", {15'd0, wrN}, {15'd0, eWr});
      chk(tStr, "loPortOe", {15'd0, loPortOe}, {15'd0, eOe});
      if (eOe) chk(tStr, "loPortOut", {8'd0, loPortOut}, {8'd0, eLo});
      chk(tHi, "hiPortOut", {8'd0, hiPortOut}, {8'd0, eHi});
      chk(ext ? "R4" : "R6", "rdValid", {15'd0, rdValid}, {15'd0, eVal});
      if (eVal) chk(ext ? "R4" : "R6", "rdData", {8'd0, rdData}, {8'd0, eData});
      if (s < 11) @(negedge clk);
    end
  endtask

  initial begin
    arstN = 1'b0; rstPin = 1'b0; reqValid = 1'b0; reqKind = 2'b00;
    reqWrite = 1'b0; reqAddr = '0; reqWdata = '0; aleOff = 1'b0;
    internalRomEn = 1'b0; hiLatch = 8'h00; respAddr = '0;
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 2);
    // R1: power-on state
    chk("R1", "coreReset por", {15'd0, coreReset}, 16'd1);
    chk("R1", "ale in reset", {15'd0, ale}, 16'd0);
    chk("R1", "psenN in reset", {15'd0, psenN}, 16'd1);
    @(negedge clk); arstN = 1'b1;
    @(negedge clk);
    chk("R1", "coreReset after pin low", {15'd0, coreReset}, 16'd0);
    // R1: 23 high edges are not enough
    rstPin = 1'b1;
    repeat (23) @(negedge clk);
    chk("R1", "coreReset after 23", {15'd0, coreReset}, 16'd0);
    rstPin = 1'b0;
    @(negedge clk);
    rstPin = 1'b1;
    repeat (23) @(negedge clk);
    chk("R1", "coreReset count restarted", {15'd0, coreReset}, 16'd0);
    @(negedge clk);
    chk("R1", "coreReset after 24", {15'd0, coreReset}, 16'd1);
    repeat (5) @(negedge clk);
    chk("R1", "rdN held in reset", {15'd0, rdN}, 16'd1);
    chk("R1", "wrN held in reset", {15'd0, wrN}, 16'd1);
    chk("R1", "loPortOe held in reset", {15'd0, loPortOe}, 16'd0);
    chk("R1", "ale held in reset", {15'd0, ale}, 16'd0);
    rstPin = 1'b0;
    @(negedge clk);
    chk("R1", "coreReset released", {15'd0, coreReset}, 16'd0);

    // directed corners
    runCycle(1'b0, 2'b00, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, 8'hA5);  // R11 idle
    runCycle(1'b1, 2'b00, 1'b0, 16'h12FF, 8'h00, 1'b0, 1'b0, 8'h00);  // R3 carry into hi
    runCycle(1'b1, 2'b00, 1'b0, 16'hFFFF, 8'h00, 1'b0, 1'b0, 8'h00);  // R3 wrap
    runCycle(1'b1, 2'b10, 1'b0, 16'hBEEF, 8'h00, 1'b0, 1'b0, 8'h11);  // R6 R8
    runCycle(1'b1, 2'b11, 1'b1, 16'h3456, 8'hC3, 1'b0, 1'b0, 8'h7E);  // R7 R8
    runCycle(1'b1, 2'b11, 1'b0, 16'h9A44, 8'h00, 1'b0, 1'b0, 8'h5D);  // R6 R8
    runCycle(1'b1, 2'b00, 1'b0, 16'h2000, 8'h00, 1'b1, 1'b0, 8'h00);  // R10 fetch
    runCycle(1'b1, 2'b01, 1'b0, 16'h2100, 8'h00, 1'b1, 1'b0, 8'h00);  // R10 code read
    runCycle(1'b1, 2'b10, 1'b1, 16'h4001, 8'h96, 1'b1, 1'b0, 8'h00);  // R10 data
    runCycle(1'b0, 2'b00, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h3A);  // R10 idle
    runCycle(1'b1, 2'b00, 1'b0, 16'h0800, 8'h00, 1'b0, 1'b1, 8'h42);  // R9

    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic v;
      v = ($urandom % 8) != 0;
      runCycle(v, 2'($urandom % 4), 1'($urandom % 2), 16'($urandom),
               8'($urandom), ($urandom % 5) == 0, ($urandom % 4) == 0,
               8'($urandom));
    end
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule